// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block turns the status of a UART's data path into three level-sensitive interrupt lines: one asking for transmit data, one announcing receive data, and one flagging a change on the modem handshake inputs. It sits beside the FIFOs, the shift registers and the baud generator and only observes them. It takes the transmit and receive occupancy counts, the single-entry holding-register flags used when the FIFOs are bypassed, a FIFO-enable control bit, strobes for "character received" and "receive data read", a once-per-bit tick, and the two handshake inputs.

The FIFO-enable bit chooses the rule set. With the FIFOs bypassed, the transmit line asks for data whenever the holding register is free. The receive line is raised whenever the receive holding register holds a character. With the FIFOs in use, the two lines follow half-depth thresholds on the occupancy counts. The receive line also fires when a few characters sit below the threshold and the line has gone quiet: after three character times with no arrival and no read, the line rises and stays up until software drains the FIFO completely.

The handshake lines are synchronised and watched for any change in level. A change latches the modem-status interrupt, which software clears with an end-of-interrupt write strobe. All three outputs are registered, so each follows its cause one clock later.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst_n` is low, `tx_irq`, `rx_irq` and `ms_irq` are all 0.
- R2: With `fifo_en` = 0, `tx_irq` is 1 on the clock after `tx_hold_full` is 0, and 0 on the clock after it is 1.
- R3: With `fifo_en` = 1, `tx_irq` is 1 when `tx_level` is below FIFO_DEPTH/2 (8 by default) and 0 when `tx_level` is FIFO_DEPTH/2 or more.
- R4: With `fifo_en` = 0, `rx_irq` equals `rx_hold_valid` delayed by one clock.
- R5: With `fifo_en` = 1, `rx_irq` is 1 whenever `rx_level` is FIFO_DEPTH/2 or more.
- R6: With `fifo_en` = 1 and `rx_level` between 1 and FIFO_DEPTH/2 - 1, `rx_irq` rises once BITS_PER_CHAR x TIMEOUT_CHARS (30 by default) `bit_tick` pulses have been counted with no `rx_char_stb` and no `rx_read_stb`. After only 29 such pulses it stays 0.
- R7: Each `rx_char_stb` pulse and each `rx_read_stb` pulse restarts the quiet-line count from zero. An empty receive FIFO also holds the count at zero.
- R8: Once raised by the timeout, `rx_irq` stays 1 through partial reads while `rx_level` is nonzero. It drops on the clock after `rx_level` reaches 0 and does not return without a new timeout or threshold crossing.
- R9: Any change in level on `cts_in` or `dsr_in` sets `ms_irq` within three clocks, through a two-flop synchroniser. The lines count as low at reset.
- R10: A one-clock `ms_eoi` pulse clears `ms_irq`. If a synchronised line change lands on the same clock as `ms_eoi`, `ms_irq` stays 1.
- R11: In FIFO mode, `tx_hold_full` and `rx_hold_valid` have no effect on the outputs. In bypass mode, `tx_level` and `rx_level` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects threshold rules, 0 selects holding-register rules |
| tx_level | input | $clog2(FIFO_DEPTH+1) | Entries held in the transmit FIFO |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Entries held in the receive FIFO |
| tx_hold_full | input | 1 | Transmit holding register occupied (bypass mode) |
| rx_hold_valid | input | 1 | Receive holding register holds a character (bypass mode) |
| rx_char_stb | input | 1 | One-clock pulse per received character |
| rx_read_stb | input | 1 | One-clock pulse per read of receive data |
| bit_tick | input | 1 | One-clock pulse per bit period |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ms_eoi | input | 1 | Clear strobe for the modem-status interrupt |
| tx_irq | output | 1 | Transmit data request |
| rx_irq | output | 1 | Receive data available |
| ms_irq | output | 1 | Modem handshake line changed |

## Verification
The receive timeout is the hardest case to reach from the ports. It needs a small, steady FIFO count, an exact number of bit ticks with no strobes, and then the restart and drain cases on top of that. The bench paces `bit_tick` by hand. It stops one pulse short of the limit to show silence, then adds the last pulse. It inserts read and arrival strobes in the middle of a count to show the restart. The second awkward case is an end-of-interrupt write landing on the same clock as a synchronised handshake change. The bench reaches it by counting clock edges from the input change, so that `ms_eoi` is sampled on the third edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Transmit side wants data: strictly below the half-depth mark.
  function automatic logic tx_wants_data(input int unsigned level, input int unsigned depth);
    return level < (depth / 2);
  endfunction

  // Receive side holds a batch: half-depth mark or above.
  function automatic logic rx_has_batch(input int unsigned level, input int unsigned depth);
    return level >= (depth / 2);
  endfunction

  // Quiet-line limit expressed in bit ticks.
  function automatic int unsigned quiet_ticks(input int unsigned bits_per_char,
                                              input int unsigned chars);
    return bits_per_char * chars;
  endfunction

endpackage

// File: rtl/uirq_tx_cond.sv
module uirq_tx_cond
  import uirq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [LW-1:0] level,
  input  logic          hold_full,
  output logic          irq
);

  logic want_fifo;
  logic want_hold;
  logic irq_next;

  assign want_fifo = tx_wants_data(32'(level), FIFO_DEPTH);
  assign want_hold = !hold_full;
  assign irq_next  = fifo_en ? want_fifo : want_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  // R2: bypass mode follows the holding register
  a_r2_hold_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !fifo_en) |-> (irq == $past(!hold_full)));

  // R3: FIFO mode follows the half-depth mark
  a_r3_fifo_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fifo_en) |-> (irq == ($past(32'(level)) < (FIFO_DEPTH / 2))));

endmodule

// File: rtl/uirq_rx_cond.sv
module uirq_rx_cond
  import uirq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned LW            = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned TIMEOUT_CHARS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [LW-1:0] level,
  input  logic          hold_valid,
  input  logic          char_stb,
  input  logic          read_stb,
  input  logic          bit_tick,
  output logic          irq
);

  localparam int unsigned LIMIT = quiet_ticks(BITS_PER_CHAR, TIMEOUT_CHARS);
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] gap_cnt;
  logic          stale_q;
  logic          nonempty;
  logic          restart;
  logic          timeout_hit;
  logic          batch;
  logic          irq_next;

  assign nonempty    = (level != '0);
  assign batch       = rx_has_batch(32'(level), FIFO_DEPTH);
  assign restart     = char_stb || read_stb || !nonempty || !fifo_en;
  assign timeout_hit = fifo_en && nonempty && (gap_cnt == CW'(LIMIT));

  // Quiet-line counter, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 gap_cnt <= '0;
    else if (restart)                           gap_cnt <= '0;
    else if (bit_tick && gap_cnt != CW'(LIMIT)) gap_cnt <= gap_cnt + CW'(1);
  end

  // Sticky timeout flag, released only by a drained FIFO.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    stale_q <= 1'b0;
    else if (!fifo_en || !nonempty) stale_q <= 1'b0;
    else if (timeout_hit)          stale_q <= 1'b1;
  end

  assign irq_next = fifo_en ? (nonempty && (batch || stale_q || timeout_hit)) : hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  // R4: bypass mode mirrors the holding flag
  a_r4_hold_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !fifo_en) |-> (irq == $past(hold_valid)));

  // R5: threshold always raises the line
  a_r5_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fifo_en && (32'(level) >= FIFO_DEPTH / 2)) |-> irq);

  // R6: below threshold, no flag and count short of the limit keeps the line low
  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fifo_en && !stale_q && (gap_cnt != CW'(LIMIT)) &&
          (32'(level) < FIFO_DEPTH / 2)) |-> !irq);

  // R8: the flag holds the line up until the FIFO is empty
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fifo_en && stale_q && nonempty) |-> irq);

  // R8: an empty FIFO releases the flag
  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !nonempty) |-> !stale_q);

endmodule

// File: rtl/uirq_modem.sv
module uirq_modem #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  input  logic             eoi,
  output logic             irq
);

  logic [LINES-1:0] sync_w;
  logic [LINES-1:0] prev_q;
  logic             chg;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_sync
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= lines_in[gi];
        stab_q <= meta_q;
      end
    end
    assign sync_w[gi] = stab_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_w;
  end

  assign chg = |(sync_w ^ prev_q);

  // A change wins over a clear on the same clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (chg) irq <= 1'b1;
    else if (eoi) irq <= 1'b0;
  end

  // R9: a detected change sets the line
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && chg) |-> irq);

  // R9: the line rises only after a detected change
  a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(irq)) |-> $past(chg));

  // R10: a clear with no change drops the line
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && eoi && !chg) |-> !irq);

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned TIMEOUT_CHARS = 3,
  parameter int unsigned LW            = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_hold_full,
  input  logic          rx_hold_valid,
  input  logic          rx_char_stb,
  input  logic          rx_read_stb,
  input  logic          bit_tick,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          ms_eoi,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          ms_irq
);

  localparam int unsigned MODEM_LINES = 2;

  logic [MODEM_LINES-1:0] modem_lines;
  assign modem_lines = {dsr_in, cts_in};

  uirq_tx_cond #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LW         (LW)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .level     (tx_level),
    .hold_full (tx_hold_full),
    .irq       (tx_irq)
  );

  uirq_rx_cond #(
    .FIFO_DEPTH    (FIFO_DEPTH),
    .LW            (LW),
    .BITS_PER_CHAR (BITS_PER_CHAR),
    .TIMEOUT_CHARS (TIMEOUT_CHARS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .level      (rx_level),
    .hold_valid (rx_hold_valid),
    .char_stb   (rx_char_stb),
    .read_stb   (rx_read_stb),
    .bit_tick   (bit_tick),
    .irq        (rx_irq)
  );

  uirq_modem #(
    .LINES (MODEM_LINES)
  ) u_modem (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_in (modem_lines),
    .eoi      (ms_eoi),
    .irq      (ms_irq)
  );

endmodule

// File: tb/uart_irq_gen_tb.sv
`timescale 1ns/1ps
module uart_irq_gen_tb;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned LW    = $clog2(DEPTH + 1);
  localparam int unsigned QUIET = 10 * 3;
  localparam int          NVEC  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b0;
  logic [LW-1:0] tx_level = '0;
  logic [LW-1:0] rx_level = '0;
  logic          tx_hold_full = 1'b0;
  logic          rx_hold_valid = 1'b0;
  logic          rx_char_stb = 1'b0;
  logic          rx_read_stb = 1'b0;
  logic          bit_tick = 1'b0;
  logic          cts_in = 1'b0;
  logic          dsr_in = 1'b0;
  logic          ms_eoi = 1'b0;
  logic          tx_irq, rx_irq, ms_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_hold_full(tx_hold_full), .rx_hold_valid(rx_hold_valid),
    .rx_char_stb(rx_char_stb), .rx_read_stb(rx_read_stb), .bit_tick(bit_tick),
    .cts_in(cts_in), .dsr_in(dsr_in), .ms_eoi(ms_eoi),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .ms_irq(ms_irq)
  );

  // Vector: {fifo_en, tx_level[5], rx_level[5], tx_hold_full, rx_hold_valid, exp_tx, exp_rx}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 5'd10, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 5'd0,  5'd0,  1'b0, 1'b1, 1'b1, 1'b1},
    {1'b0, 5'd16, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'd0,  5'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 5'd7,  5'd7,  1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 5'd8,  5'd8,  1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 5'd16, 5'd16, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 5'd1,  5'd1,  1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 5'd9,  5'd15, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'd3,  5'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 5'd3,  5'd3,  1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic pulse_char();
    @(negedge clk); rx_char_stb = 1'b1;
    @(negedge clk); rx_char_stb = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rx_read_stb = 1'b1;
    @(negedge clk); rx_read_stb = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); ms_eoi = 1'b1;
    @(negedge clk); ms_eoi = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: outputs quiet in reset even with inputs that would raise them
    tx_hold_full = 1'b0;
    rx_hold_valid = 1'b1;
    idle(4);
    chk("R1 tx_irq in reset", tx_irq, 1'b0);
    chk("R1 rx_irq in reset", rx_irq, 1'b0);
    chk("R1 ms_irq in reset", ms_irq, 1'b0);
    rx_hold_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 R5 R11: threshold and mode table
    for (int v = 0; v < NVEC; v++) begin
      fifo_en       = VEC[v][14];
      tx_level      = VEC[v][13:9];
      rx_level      = VEC[v][8:4];
      tx_hold_full  = VEC[v][3];
      rx_hold_valid = VEC[v][2];
      idle(2);
      chk($sformatf("R2/R3/R11 tx vector %0d", v), tx_irq, VEC[v][1]);
      chk($sformatf("R4/R5/R11 rx vector %0d", v), rx_irq, VEC[v][0]);
    end

    // R6: timeout limit exactly
    fifo_en = 1'b1; tx_hold_full = 1'b0; rx_hold_valid = 1'b0;
    tx_level = 5'd8; rx_level = 5'd2;
    pulse_char();
    ticks(QUIET - 1);
    idle(3);
    chk("R6 silent after limit-1 ticks", rx_irq, 1'b0);
    ticks(1);
    idle(3);
    chk("R6 raised at limit", rx_irq, 1'b1);

    // R8: partial read keeps it, drain drops it, refill stays quiet
    rx_level = 5'd1;
    pulse_read();
    idle(2);
    chk("R8 held through partial read", rx_irq, 1'b1);
    ticks(5);
    chk("R8 still held", rx_irq, 1'b1);
    @(negedge clk); rx_level = 5'd0;
    idle(2);
    chk("R8 dropped when empty", rx_irq, 1'b0);
    rx_level = 5'd1;
    idle(3);
    chk("R8 no return after refill", rx_irq, 1'b0);

    // R7: read strobe restarts the count
    rx_level = 5'd0; idle(2);
    rx_level = 5'd2;
    ticks(20);
    pulse_read();
    ticks(20);
    idle(2);
    chk("R7 read restarts count", rx_irq, 1'b0);
    ticks(10);
    idle(3);
    chk("R7 fires full limit after read", rx_irq, 1'b1);

    // R7: character strobe restarts the count
    rx_level = 5'd0; idle(2);
    rx_level = 5'd3;
    ticks(25);
    pulse_char();
    ticks(25);
    idle(2);
    chk("R7 char restarts count", rx_irq, 1'b0);
    // R7: empty FIFO holds count at zero
    rx_level = 5'd0;
    ticks(40);
    rx_level = 5'd3;
    idle(3);
    chk("R7 empty holds count", rx_irq, 1'b0);

    // R9: handshake changes
    @(negedge clk); cts_in = 1'b1;
    idle(1);
    chk("R9 not set before sync", ms_irq, 1'b0);
    idle(4);
    chk("R9 set on cts rise", ms_irq, 1'b1);
    pulse_eoi();
    idle(1);
    chk("R10 cleared by eoi", ms_irq, 1'b0);
    @(negedge clk); dsr_in = 1'b1;
    idle(5);
    chk("R9 set on dsr rise", ms_irq, 1'b1);
    pulse_eoi();
    idle(3);
    chk("R10 stays clear without change", ms_irq, 1'b0);
    @(negedge clk); cts_in = 1'b0;
    idle(5);
    chk("R9 set on cts fall", ms_irq, 1'b1);

    // R10: change and clear meet on the same clock
    @(negedge clk); dsr_in = 1'b0;
    @(negedge clk);
    @(negedge clk); ms_eoi = 1'b1;
    @(negedge clk); ms_eoi = 1'b0;
    chk("R10 change beats eoi", ms_irq, 1'b1);
    pulse_eoi();
    idle(1);
    chk("R10 later eoi clears", ms_irq, 1'b0);

    finish_run();
  end

endmodule